// File: doc/BRIEF.md
# Array-Copy Loop Offload Core with Patch Points

This block stands in for a short software loop that copies `n` words from one array to another, one element per pass. A host processor programs a source base, a destination base and an element count into a small register file, then writes a start command. The core then steps through the loop by itself and raises a done flag when the loop exits. It issues the same loads and stores, in the same order, that the compiled loop would issue on the processor. All accesses go through one request/response memory port toward a data cache.

The controller is a direct image of the loop's control flow graph. Each of its four basic blocks is its own control state: entry, header test, body, and exit. The body's memory accesses wait in self-looping states for as long as the memory takes. The datapath has one unit for each source operation: an index register with an input multiplexer, an incrementer, an unsigned less-than comparator against the count, and one load and one store path.

Two patch mechanisms let the hardware follow small changes to the loop's source. Patch registers override the index start value and the step. A per-block patch mask makes the core stop before running a marked block and hand control back to the host. The index stays in the core, where the host can read and rewrite it. The host then resumes the core at a basic block of its choosing.

Top module: `loop_offload_core`

## Requirements
- R1: After reset, `done`, `handoff` and `mem_req_valid` are 0. The start-value register (offset 4) reads 0, the step register (offset 5) reads 1 and the patch mask (offset 6) reads 0.
- R2: The host register map uses word offsets 0 = source base, 1 = destination base, 2 = element count n, 3 = control/status, 4 = start value, 5 = step, 6 = patch mask, 7 = loop index. Offsets 0, 1, 2, 4 and 5 read back the value last written.
- R3: Writing offset 3 with bit 0 set starts the loop, but only while the core is idle. Such a write while a loop or a handoff is in progress has no effect. `done` (also status bit 0) clears on an accepted start and stays set from loop exit until the next accepted start.
- R4: For i = start, start+step, ... while i < n (unsigned), the core loads the word at word address source+i. It then stores the loaded value to destination+i. It makes no other accesses and performs them in exactly this order.
- R5: When the start value is not below n (for example n = 0), the core makes no memory access and sets `done`.
- R6: Every request holds `mem_req_valid`, address, write flag and write data steady until `mem_req_ready`. Only one access is outstanding at a time. The core waits for `mem_rsp_valid`, however late it comes, before it goes on. A store also waits for a response.
- R7: The values in the start and step registers replace the constants 0 and 1 of the loop.
- R8: Patch mask bit b marks basic block b, where 0 = entry, 1 = header, 2 = body and 3 = exit. When the core is about to enter a marked block, it skips that block's work, raises `handoff` and reports b in status bits 3:2 (status bit 1 mirrors `handoff`). The index keeps its value and reads back at offset 7.
- R9: During a handoff, a write to offset 7 replaces the index. Writing offset 3 with bit 1 set and a block code in bits 3:2 drops `handoff` and enters that block, again subject to the patch mask. Index writes outside a handoff have no effect.
- R10: `done` and `handoff` are never both high, and no memory request is made while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset for write and read |
| reg_wdata | input | AW (16) | Host write data |
| reg_rdata | output | AW (16) | Read data of the register at `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | AW (16) | Word address of the access |
| mem_req_wdata | output | DW (32) | Store data |
| mem_rsp_valid | input | 1 | Response for the outstanding access |
| mem_rsp_data | input | DW (32) | Load data |
| done | output | 1 | Loop has exited; held until next start |
| handoff | output | 1 | Core waits for the host to run a patched block |

## Verification
The hardest situations to reach from the ports are the handoffs at each of the four block boundaries, together with a correct resumption of the loop afterwards. The header and exit cases matter most, because the core must stop before the comparator or the done flag acts. The bench reaches them by programming one mask bit at a time. It then acts as the host stub. It reads the status and the saved index, copies elements itself when the body is patched, rewrites the index, and resumes at the successor block. Where the same block would otherwise trap again, it clears the mask first. A sweep over count, start value and step, run against a memory model with varying ready stalls and response delays, covers the empty-loop, strided and self-loop waiting cases.

// File: rtl/lo_pkg.sv
package lo_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTRY,
        S_HEAD,
        S_LD_REQ,
        S_LD_RSP,
        S_ST_REQ,
        S_ST_RSP,
        S_EXIT,
        S_HAND
    } ctl_state_e;

    typedef enum logic [1:0] {
        IDX_HOLD,
        IDX_INIT,
        IDX_STEP,
        IDX_HOST
    } idx_sel_e;

    localparam int NUM_BB = 4;
    localparam int BBW    = $clog2(NUM_BB);

    localparam logic [BBW-1:0] BB_ENTRY = 2'd0;
    localparam logic [BBW-1:0] BB_HEAD  = 2'd1;
    localparam logic [BBW-1:0] BB_BODY  = 2'd2;
    localparam logic [BBW-1:0] BB_EXIT  = 2'd3;

    localparam int RAW = 3;
    localparam logic [RAW-1:0] RA_SRC  = 3'd0;
    localparam logic [RAW-1:0] RA_DST  = 3'd1;
    localparam logic [RAW-1:0] RA_CNT  = 3'd2;
    localparam logic [RAW-1:0] RA_CTRL = 3'd3;
    localparam logic [RAW-1:0] RA_INIT = 3'd4;
    localparam logic [RAW-1:0] RA_STEP = 3'd5;
    localparam logic [RAW-1:0] RA_MASK = 3'd6;
    localparam logic [RAW-1:0] RA_IDX  = 3'd7;

endpackage

// File: rtl/lo_regs.sv
module lo_regs
    import lo_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RAW-1:0]       addr,
    input  logic [AW-1:0]        wdata,
    output logic [AW-1:0]        rdata,
    input  logic [AW-1:0]        idx,
    input  logic                 done,
    input  logic                 handoff,
    input  logic [BBW-1:0]       blk,
    output logic [AW-1:0]        src,
    output logic [AW-1:0]        dst,
    output logic [AW-1:0]        cnt,
    output logic [AW-1:0]        init,
    output logic [AW-1:0]        step,
    output logic [NUM_BB-1:0]    mask,
    output logic                 start,
    output logic                 resume,
    output logic [BBW-1:0]       resume_tgt,
    output logic                 idx_we,
    output logic [AW-1:0]        idx_wval
);

    typedef struct packed {
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [AW-1:0]     cnt;
        logic [AW-1:0]     init;
        logic [AW-1:0]     step;
        logic [NUM_BB-1:0] mask;
    } regs_t;

    regs_t q, d;
    logic  ctrl_wr;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                RA_SRC:  d.src  = wdata;
                RA_DST:  d.dst  = wdata;
                RA_CNT:  d.cnt  = wdata;
                RA_INIT: d.init = wdata;
                RA_STEP: d.step = wdata;
                RA_MASK: d.mask = wdata[NUM_BB-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{src: '0, dst: '0, cnt: '0, init: '0,
                   step: AW'(1), mask: '0};
        end else begin
            q <= d;
        end
    end

    assign ctrl_wr    = wr_en && (addr == RA_CTRL);
    assign start      = ctrl_wr && wdata[0];
    assign resume     = ctrl_wr && wdata[1];
    assign resume_tgt = wdata[BBW+1:2];
    assign idx_we     = wr_en && (addr == RA_IDX);
    assign idx_wval   = wdata;

    assign src  = q.src;
    assign dst  = q.dst;
    assign cnt  = q.cnt;
    assign init = q.init;
    assign step = q.step;
    assign mask = q.mask;

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SRC:  rdata = q.src;
            RA_DST:  rdata = q.dst;
            RA_CNT:  rdata = q.cnt;
            RA_CTRL: begin
                rdata[0]       = done;
                rdata[1]       = handoff;
                rdata[BBW+1:2] = blk;
            end
            RA_INIT: rdata = q.init;
            RA_STEP: rdata = q.step;
            RA_MASK: rdata[NUM_BB-1:0] = q.mask;
            default: rdata = idx;
        endcase
    end

endmodule

// File: rtl/lo_datapath.sv
module lo_datapath
    import lo_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  idx_sel_e      idx_sel,
    input  logic [AW-1:0] init,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] host_idx,
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          is_store,
    input  logic          ld_cap,
    input  logic [DW-1:0] rsp_data,
    output logic [AW-1:0] idx,
    output logic          lt,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic [DW-1:0] ld;
    } dp_t;

    dp_t q, d;
    logic [AW-1:0] idx_inc;

    assign idx_inc = q.idx + step;

    always_comb begin
        d = q;
        case (idx_sel)
            IDX_INIT: d.idx = init;
            IDX_STEP: d.idx = idx_inc;
            IDX_HOST: d.idx = host_idx;
            default:  d.idx = q.idx;
        endcase
        if (ld_cap) begin
            d.ld = rsp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{idx: '0, ld: '0};
        end else begin
            q <= d;
        end
    end

    assign idx   = q.idx;
    assign lt    = q.idx < cnt;
    assign addr  = is_store ? (dst + q.idx) : (src + q.idx);
    assign wdata = q.ld;

endmodule

// File: rtl/lo_ctrl.sv
module lo_ctrl
    import lo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resume,
    input  logic [BBW-1:0]    resume_tgt,
    input  logic              host_idx_we,
    input  logic [NUM_BB-1:0] mask,
    input  logic              lt,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output idx_sel_e          idx_sel,
    output logic              req_valid,
    output logic              is_store,
    output logic              ld_cap,
    output logic              done,
    output logic              handoff,
    output logic [BBW-1:0]    blk
);

    typedef struct packed {
        ctl_state_e     state;
        logic           done;
        logic           handoff;
        logic [BBW-1:0] blk;
    } ctl_t;

    ctl_t q, d;
    logic           go;
    logic [BBW-1:0] tgt;

    function automatic ctl_state_e block_state(input logic [BBW-1:0] b);
        case (b)
            BB_ENTRY: return S_ENTRY;
            BB_HEAD:  return S_HEAD;
            BB_BODY:  return S_LD_REQ;
            default:  return S_EXIT;
        endcase
    endfunction

    always_comb begin
        d         = q;
        go        = 1'b0;
        tgt       = BB_ENTRY;
        idx_sel   = IDX_HOLD;
        req_valid = 1'b0;
        is_store  = 1'b0;
        ld_cap    = 1'b0;

        case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.done = 1'b0;
                    go     = 1'b1;
                    tgt    = BB_ENTRY;
                end
            end
            S_ENTRY: begin
                idx_sel = IDX_INIT;
                go      = 1'b1;
                tgt     = BB_HEAD;
            end
            S_HEAD: begin
                go  = 1'b1;
                tgt = lt ? BB_BODY : BB_EXIT;
            end
            S_LD_REQ: begin
                req_valid = 1'b1;
                if (req_ready) begin
                    d.state = S_LD_RSP;
                end
            end
            S_LD_RSP: begin
                if (rsp_valid) begin
                    ld_cap  = 1'b1;
                    d.state = S_ST_REQ;
                end
            end
            S_ST_REQ: begin
                req_valid = 1'b1;
                is_store  = 1'b1;
                if (req_ready) begin
                    d.state = S_ST_RSP;
                end
            end
            S_ST_RSP: begin
                is_store = 1'b1;
                if (rsp_valid) begin
                    idx_sel = IDX_STEP;
                    go      = 1'b1;
                    tgt     = BB_HEAD;
                end
            end
            S_EXIT: begin
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            S_HAND: begin
                if (host_idx_we) begin
                    idx_sel = IDX_HOST;
                end
                if (resume) begin
                    d.handoff = 1'b0;
                    go        = 1'b1;
                    tgt       = resume_tgt;
                end
            end
            default: d.state = S_IDLE;
        endcase

        if (go) begin
            if (mask[tgt]) begin
                d.state   = S_HAND;
                d.handoff = 1'b1;
                d.blk     = tgt;
            end else begin
                d.state = block_state(tgt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, done: 1'b0, handoff: 1'b0, blk: '0};
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign handoff = q.handoff;
    assign blk     = q.blk;

endmodule

// File: rtl/loop_offload_core.sv
module loop_offload_core
    import lo_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr_en,
    input  logic [RAW-1:0] reg_addr,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  reg_rdata,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic           mem_req_write,
    output logic [AW-1:0]  mem_req_addr,
    output logic [DW-1:0]  mem_req_wdata,
    input  logic           mem_rsp_valid,
    input  logic [DW-1:0]  mem_rsp_data,
    output logic           done,
    output logic           handoff
);

    logic [AW-1:0]     src, dst, cnt, init, step, idx, idx_wval;
    logic [NUM_BB-1:0] mask;
    logic              start, resume, idx_we, lt, ld_cap;
    logic [BBW-1:0]    resume_tgt, blk;
    idx_sel_e          idx_sel;

    lo_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .idx        (idx),
        .done       (done),
        .handoff    (handoff),
        .blk        (blk),
        .src        (src),
        .dst        (dst),
        .cnt        (cnt),
        .init       (init),
        .step       (step),
        .mask       (mask),
        .start      (start),
        .resume     (resume),
        .resume_tgt (resume_tgt),
        .idx_we     (idx_we),
        .idx_wval   (idx_wval)
    );

    lo_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .resume      (resume),
        .resume_tgt  (resume_tgt),
        .host_idx_we (idx_we),
        .mask        (mask),
        .lt          (lt),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .idx_sel     (idx_sel),
        .req_valid   (mem_req_valid),
        .is_store    (mem_req_write),
        .ld_cap      (ld_cap),
        .done        (done),
        .handoff     (handoff),
        .blk         (blk)
    );

    lo_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_sel  (idx_sel),
        .init     (init),
        .step     (step),
        .host_idx (idx_wval),
        .cnt      (cnt),
        .src      (src),
        .dst      (dst),
        .is_store (mem_req_write),
        .ld_cap   (ld_cap),
        .rsp_data (mem_rsp_data),
        .idx      (idx),
        .lt       (lt),
        .addr     (mem_req_addr),
        .wdata    (mem_req_wdata)
    );

endmodule

// File: rtl/lo_checker.sv
module lo_checker
    import lo_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr_en,
    input logic [RAW-1:0] reg_addr,
    input logic [AW-1:0]  reg_wdata,
    input logic           mem_req_valid,
    input logic           mem_req_ready,
    input logic           mem_req_write,
    input logic [AW-1:0]  mem_req_addr,
    input logic [DW-1:0]  mem_req_wdata,
    input logic           mem_rsp_valid,
    input logic [DW-1:0]  mem_rsp_data,
    input logic           done,
    input logic           handoff
);

    logic          out_q, out_w_q, have_ld_q;
    logic [DW-1:0] last_ld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= 1'b0;
            out_w_q   <= 1'b0;
            have_ld_q <= 1'b0;
            last_ld_q <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                out_q   <= 1'b1;
                out_w_q <= mem_req_write;
            end else if (mem_rsp_valid) begin
                out_q <= 1'b0;
            end
            if (mem_rsp_valid && out_q && !out_w_q) begin
                last_ld_q <= mem_rsp_data;
                have_ld_q <= 1'b1;
            end
        end
    end

    // R6: a request waiting for ready holds its fields
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
            && $stable(mem_req_wdata));

    // R6: no new request while one is outstanding
    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !mem_req_valid);

    // R4: stored value is the most recent load response
    a_r4_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> have_ld_q && mem_req_wdata == last_ld_q);

    // R10: done and handoff exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && handoff));

    // R10: no requests while finished or handed off
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done || handoff) |-> !mem_req_valid);

    // R3: done only drops after a start command
    a_r3_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(reg_wr_en && reg_addr == RA_CTRL && reg_wdata[0]));

endmodule

bind loop_offload_core lo_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_loop_offload_core.sv
module tb_loop_offload_core;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam logic [AW-1:0] SRC = 16'd16;
    localparam logic [AW-1:0] DST = 16'd128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          mem_req_valid, mem_req_write;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          done, handoff;

    always #10 clk = ~clk;

    loop_offload_core #(.AW(AW), .DW(DW)) dut (.*);

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model
    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] tr_a [0:63];
    logic          tr_w [0:63];
    logic [DW-1:0] tr_d [0:63];
    int            tr_n = 0;
    int            ms = 0;
    int            stall = 0;
    int            lat = 0;
    logic [7:0]    lf = 8'h5a;
    logic [AW-1:0] cap_a = '0;
    logic          cap_w = 1'b0;
    logic [DW-1:0] cap_d = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ms = 0;
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
        end else begin
            case (ms)
                0: if (mem_req_valid) begin
                    if (stall == 0) begin
                        mem_req_ready = 1'b1;
                        cap_a = mem_req_addr;
                        cap_w = mem_req_write;
                        cap_d = mem_req_wdata;
                        ms = 1;
                    end else begin
                        stall--;
                    end
                end
                1: begin
                    mem_req_ready = 1'b0;
                    if (tr_n < 64) begin
                        tr_a[tr_n] = cap_a;
                        tr_w[tr_n] = cap_w;
                        tr_d[tr_n] = cap_d;
                    end
                    tr_n++;
                    if (cap_w) mem[cap_a[7:0]] = cap_d;
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    lat = int'(lf[1:0]);
                    ms = 2;
                end
                2: if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = cap_w ? '0 : mem[cap_a[7:0]];
                    ms = 3;
                end else begin
                    lat--;
                end
                default: begin
                    mem_rsp_valid = 1'b0;
                    stall = int'(lf[3:2]) % 3;
                    ms = 0;
                end
            endcase
        end
    end

    task automatic wr(input logic [2:0] a, input logic [AW-1:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [AW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_evt(input string tag);
        bit ok = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            #2;
            if (done || handoff) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok, {tag, " event wait"}, 64'(ok), 64'd1);
    endtask

    task automatic prep(input int seed);
        for (int j = 0; j < 256; j++) mem[j] = (32'(j) * 32'h01010101) ^ 32'(seed * 977);
        for (int j = 0; j < 16; j++) mem[DST[7:0] + 8'(j)] = '0;
        tr_n = 0;
    endtask

    function automatic bit in_set(input int j, input int first, input int n, input int step);
        return (j >= first) && (j < n) && (((j - first) % step) == 0);
    endfunction

    // expected access trace and destination contents
    task automatic chk_copy(input string tag, input int first, input int n, input int step,
                            input bit hw);
        int  k = 0;
        bit  ok = 1'b1;
        int  exp_n = 0;
        for (int i = first; i < n; i += step) exp_n += 2;
        if (!hw) exp_n = 0;
        chk(tr_n == exp_n, {tag, " R4 R6 access count"}, 64'(tr_n), 64'(exp_n));
        if (hw && tr_n == exp_n) begin
            for (int i = first; i < n; i += step) begin
                if (tr_w[k] !== 1'b0 || tr_a[k] !== SRC + AW'(i)) ok = 1'b0;
                if (tr_w[k+1] !== 1'b1 || tr_a[k+1] !== DST + AW'(i) ||
                    tr_d[k+1] !== mem[SRC[7:0] + 8'(i)]) ok = 1'b0;
                k += 2;
            end
            chk(ok, {tag, " R4 access order"}, 64'(ok), 64'd1);
        end
        ok = 1'b1;
        for (int j = 0; j < 16; j++) begin
            if (mem[DST[7:0] + 8'(j)] !==
                (in_set(j, first, n, step) ? mem[SRC[7:0] + 8'(j)] : '0)) ok = 1'b0;
        end
        chk(ok, {tag, " R4 destination contents"}, 64'(ok), 64'd1);
    endtask

    task automatic run_loop(input int first, input int n, input int step);
        string tag;
        tag = $sformatf("R4 R7 n=%0d first=%0d step=%0d", n, first, step);
        prep(n * 31 + first * 7 + step);
        wr(3'd4, AW'(first));
        wr(3'd5, AW'(step));
        wr(3'd2, AW'(n));
        wr(3'd3, 16'h0001);
        #2;
        chk(done == 1'b0, {tag, " R3 done cleared by start"}, 64'(done), 64'd0);
        wait_evt(tag);
        chk(done && !handoff, {tag, (first >= n) ? " R5 empty loop done" : " done"},
            64'({done, handoff}), 64'b10);
        chk_copy(tag, first, n, step, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [AW-1:0] v;
        int            hcount;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk({done, handoff, mem_req_valid} == 3'b000, "R1 outputs after reset",
            64'({done, handoff, mem_req_valid}), 64'd0);
        rd(3'd4, v); chk(v == 16'd0, "R1 start value reset", 64'(v), 64'd0);
        rd(3'd5, v); chk(v == 16'd1, "R1 step reset", 64'(v), 64'd1);
        rd(3'd6, v); chk(v == 16'd0, "R1 mask reset", 64'(v), 64'd0);

        wr(3'd0, SRC);
        wr(3'd1, DST);
        wr(3'd2, 16'h00a5);
        rd(3'd0, v); chk(v == SRC, "R2 source readback", 64'(v), 64'(SRC));
        rd(3'd1, v); chk(v == DST, "R2 destination readback", 64'(v), 64'(DST));
        rd(3'd2, v); chk(v == 16'h00a5, "R2 count readback", 64'(v), 64'h00a5);
        wr(3'd4, 16'h0003);
        rd(3'd4, v); chk(v == 16'h0003, "R2 R7 start value readback", 64'(v), 64'h3);
        wr(3'd5, 16'h0002);
        rd(3'd5, v); chk(v == 16'h0002, "R2 R7 step readback", 64'(v), 64'h2);

        // sweep count, start value, step
        for (int n = 0; n <= 5; n++)
            for (int first = 0; first <= 2; first++)
                for (int step = 1; step <= 3; step++)
                    run_loop(first, n, step);

        // done held until next start
        v = AW'(tr_n);
        repeat (20) @(negedge clk);
        #2;
        chk(done && !handoff && tr_n == int'(v), "R3 done held while idle",
            64'({done, handoff}), 64'b10);

        // start while busy is ignored
        prep(99);
        wr(3'd4, 16'd0); wr(3'd5, 16'd1); wr(3'd2, 16'd4);
        wr(3'd3, 16'h0001);
        wr(3'd3, 16'h0001);
        wait_evt("R3 busy start");
        chk_copy("R3 busy start ignored", 0, 4, 1, 1'b1);

        // body patch: host performs every iteration
        prep(5);
        wr(3'd2, 16'd3); wr(3'd6, 16'h0004);
        wr(3'd3, 16'h0001);
        hcount = 0;
        for (int it = 0; it < 6; it++) begin
            wait_evt("R8 body");
            if (done) break;
            rd(3'd3, v);
            chk(v[3:0] == 4'b1010, "R8 status shows body handoff", 64'(v[3:0]), 64'b1010);
            chk(!(done && handoff), "R10 exclusive flags", 64'({done, handoff}), 64'b01);
            rd(3'd7, v);
            chk(v == AW'(hcount), "R8 saved index", 64'(v), 64'(hcount));
            mem[DST[7:0] + v[7:0]] = mem[SRC[7:0] + v[7:0]];
            wr(3'd7, v + 16'd1);
            wr(3'd3, 16'h0002 | (16'd1 << 2));
            hcount++;
        end
        chk(hcount == 3 && done, "R8 R9 body handoff count", 64'(hcount), 64'd3);
        chk_copy("R8 R9 host-run body", 0, 3, 1, 1'b0);

        // entry patch: host supplies start index
        prep(6);
        wr(3'd2, 16'd5); wr(3'd6, 16'h0001);
        wr(3'd7, 16'd9);
        wr(3'd3, 16'h0001);
        wait_evt("R8 entry");
        rd(3'd3, v);
        chk(v[3:0] == 4'b0010, "R8 status shows entry handoff", 64'(v[3:0]), 64'b0010);
        wr(3'd7, 16'd2);
        rd(3'd7, v);
        chk(v == 16'd2, "R9 index written during handoff", 64'(v), 64'd2);
        wr(3'd3, 16'h0002 | (16'd1 << 2));
        wait_evt("R9 entry resume");
        chk(done, "R9 done after entry resume", 64'(done), 64'd1);
        chk_copy("R9 resume after entry", 2, 5, 1, 1'b1);

        // exit patch
        prep(7);
        wr(3'd2, 16'd2); wr(3'd6, 16'h0008);
        wr(3'd3, 16'h0001);
        wait_evt("R8 exit");
        chk({done, handoff} == 2'b01, "R8 exit handoff keeps done low",
            64'({done, handoff}), 64'b01);
        rd(3'd3, v);
        chk(v[3:2] == 2'd3, "R8 exit block code", 64'(v[3:2]), 64'd3);
        chk_copy("R8 before exit", 0, 2, 1, 1'b1);
        wr(3'd6, 16'h0000);
        wr(3'd3, 16'h0002 | (16'd3 << 2));
        wait_evt("R9 exit resume");
        chk({done, handoff} == 2'b10, "R9 done after exit resume",
            64'({done, handoff}), 64'b10);

        // header patch: resume into body, then exit
        prep(8);
        wr(3'd2, 16'd1); wr(3'd6, 16'h0002);
        wr(3'd3, 16'h0001);
        wait_evt("R8 header");
        rd(3'd3, v);
        chk(v[3:0] == 4'b0110, "R8 header handoff status", 64'(v[3:0]), 64'b0110);
        rd(3'd7, v);
        chk(v == 16'd0, "R8 header index", 64'(v), 64'd0);
        wr(3'd3, 16'h0001);
        #2;
        chk(handoff && !done, "R3 start ignored during handoff", 64'({done, handoff}), 64'b01);
        wr(3'd3, 16'h0002 | (16'd2 << 2));
        wait_evt("R9 body resume");
        chk(handoff, "R8 header trap after body", 64'(handoff), 64'd1);
        rd(3'd7, v);
        chk(v == 16'd1, "R9 index after resumed body", 64'(v), 64'd1);
        wr(3'd3, 16'h0002 | (16'd3 << 2));
        wait_evt("R9 exit");
        chk(done && !handoff, "R9 done after header path", 64'({done, handoff}), 64'b10);
        chk_copy("R9 header path", 0, 1, 1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule